// File: doc/BRIEF.md
# SDRAM Burst Truncation Sequencer

This block sits on the controller side of a single-data-rate SDRAM and turns host requests into a cycle-exact command stream. A host asks for a row activation, a read burst, a write burst or a mode-register load. For reads and writes it also gives the number of beats to transfer and one of two ways to end the burst early: a burst-terminate command or a bank precharge. On every clock the sequencer drives the encoded command pins, the bank address, the A10 line, the DQM mask, a strobe that marks the cycles in which write data must be on the bus, and a strobe that marks the cycles in which read data must be captured.

Read capture is sized from the CAS latency so that the beats the device still returns after the terminating command are collected. Write beats after the last wanted one are masked with DQM until the precharge. Precharges are delayed until the bank has been active long enough. A mode-register load first closes all banks if any is open, waits the precharge time, and then keeps the bus quiet for two cycles. Requests use a valid/ready handshake and are accepted only when the sequencer is idle.

Top module: `sdr_trunc_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the sequencer is idle. While idle the command pins carry NOP, and `dqm`, `wr_valid` and `rd_capture` are 0. A request accepted at a rising edge puts its first command on the bus in the following cycle, called t=0.
- R2: Command encoding on `cmd_n` = {CS_n, RAS_n, CAS_n, WE_n}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, BURST-TERMINATE 0110, PRECHARGE 0010, MODE-LOAD 0000. `req_op` codes: 0 activate, 1 read, 2 write, 3 mode load. An activate drives ACTIVATE with `req_bank` at t=0 and is idle again at t=1.
- R3: A write with `req_pre`=0 and L beats drives WRITE at t=0, `wr_valid` for t=0..L-1, and BURST-TERMINATE at t=L. DQM stays 0. The sequencer is ready at t=L+1.
- R4: A write with `req_pre`=1 drives `wr_valid` for t=0..L-1 and a single-bank PRECHARGE (A10=0) at t=p. Here p = max(L-1+T_RDL, cycles still missing for tRAS). DQM is 1 for t=L..p.
- R5: A read with `req_pre`=0 drives READ at t=0 and BURST-TERMINATE at t=L. `rd_capture` is 1 for t=CL..CL+L-1, so it stays open CL-1 cycles past the terminate when the data has started. The sequencer is ready at t=L+CL.
- R6: A read with `req_pre`=1 drives a single-bank PRECHARGE at t=p, where p = max(L, cycles still missing for tRAS). Capture is as in R5. DQM is 1 for t=L+CL-2..p+CL-3 (empty when p=L).
- R7: No PRECHARGE to a bank is issued fewer than T_RAS cycles after that bank's ACTIVATE.
- R8: A mode load with no bank open drives MODE-LOAD at t=0. Otherwise it drives PRECHARGE with A10=1 at the first t at which every open bank meets tRAS, then MODE-LOAD T_RP cycles later. The two cycles after MODE-LOAD carry NOP and ready returns in the second of them.
- R9: After a truncating PRECHARGE at t=p, ready returns at t=max(p+T_RP, last capture cycle+1).
- R10: `cas_lat`=3 selects CAS latency 3; any other value selects 2.
- R11: `req_len` encodes L-1, so the burst length L ranges over 1..2^LEN_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 2 | 0 activate, 1 read, 2 write, 3 mode load |
| req_bank | input | 2 | Target bank |
| req_len | input | LEN_W | Beats minus one |
| req_pre | input | 1 | 1: end with precharge, 0: burst terminate |
| cas_lat | input | 2 | CAS latency, 3 or 2 |
| cmd_n | output | 4 | {CS_n, RAS_n, CAS_n, WE_n} |
| cmd_a10 | output | 1 | A10, 1 for all-bank precharge |
| cmd_bank | output | 2 | Bank address |
| dqm | output | 1 | Data mask |
| wr_valid | output | 1 | Write data must be driven this cycle |
| rd_capture | output | 1 | Read data must be captured this cycle |

## Verification
The reference model is run with short and full-length writes and reads under both ways of ending a burst. Comparing the terminate-ended and precharge-ended variants separates the mask windows from the command placement. Reads at CAS latency 2 and 3, including a one-beat read at latency 3 whose data arrives only after the terminate, show whether the capture window follows the latency rather than the stop. Precharges issued right after an activate, including a mode load with two freshly opened banks, force the tRAS delay and the read mask window that it opens. A mode load with all banks closed checks that no needless precharge is issued.

// File: rtl/sdr_trunc_seq.sv
module sdr_trunc_seq #(
  parameter int T_RDL = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int LEN_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [1:0]       req_bank,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_pre,
  input  logic [1:0]       cas_lat,
  output logic [3:0]       cmd_n,
  output logic             cmd_a10,
  output logic [1:0]       cmd_bank,
  output logic             dqm,
  output logic             wr_valid,
  output logic             rd_capture
);
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_BST = 4'b0110, C_PRE = 4'b0010, C_MRS = 4'b0000;
  localparam logic [1:0] OP_ACT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_MRS = 2'd3;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t need(cnt_t age);
    return (age + cnt_t'(1) >= cnt_t'(T_RAS)) ? '0 : cnt_t'(T_RAS - 1) - age;
  endfunction
  function automatic cnt_t mx(cnt_t a, cnt_t b);
    return (a > b) ? a : b;
  endfunction

  logic       busy, pre_q, any_open, acc;
  logic [1:0] op_q, bank_q;
  logic [3:0] open_q;
  cnt_t       t_q, len_q, cl_q, pre_off_q, mrs_off_q, end_q;
  cnt_t       ras_q [4];
  cnt_t       beats, cl, need_all, pre_n, mrs_n, end_n;

  assign req_ready = !busy;
  assign acc       = req_valid && !busy;
  assign any_open  = |open_q;
  assign beats     = cnt_t'(req_len) + cnt_t'(1);
  assign cl        = (cas_lat == 2'd3) ? cnt_t'(3) : cnt_t'(2);

  always_comb begin
    need_all = '0;
    for (int b = 0; b < 4; b++)
      if (open_q[b]) need_all = mx(need_all, need(ras_q[b]));
    pre_n = mx((req_op == OP_WR) ? beats + cnt_t'(T_RDL - 1) : beats, need(ras_q[req_bank]));
    mrs_n = '0;
    case (req_op)
      OP_ACT:  end_n = '0;
      OP_WR:   end_n = req_pre ? pre_n + cnt_t'(T_RP - 1) : beats;
      OP_RD:   end_n = req_pre ? mx(pre_n + cnt_t'(T_RP - 1), beats + cl - cnt_t'(1))
                               : beats + cl - cnt_t'(1);
      default: begin
        if (any_open) begin
          pre_n = need_all;
          mrs_n = need_all + cnt_t'(T_RP);
        end
        end_n = mrs_n + cnt_t'(1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; pre_q <= 1'b0; op_q <= '0; bank_q <= '0; open_q <= '0;
      t_q <= '0; len_q <= '0; cl_q <= '0; pre_off_q <= '0; mrs_off_q <= '0; end_q <= '0;
      for (int b = 0; b < 4; b++) ras_q[b] <= cnt_t'(T_RAS);
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (acc && req_op == OP_ACT && req_bank == 2'(b)) ras_q[b] <= '0;
        else if (ras_q[b] < cnt_t'(T_RAS)) ras_q[b] <= ras_q[b] + cnt_t'(1);
      end
      if (acc) begin
        case (req_op)
          OP_ACT:  open_q[req_bank] <= 1'b1;
          OP_MRS:  open_q <= '0;
          default: if (req_pre) open_q[req_bank] <= 1'b0;
        endcase
        busy      <= 1'b1;
        t_q       <= '0;
        op_q      <= req_op;
        bank_q    <= req_bank;
        len_q     <= beats;
        cl_q      <= cl;
        pre_q     <= (req_op == OP_MRS) ? any_open : req_pre;
        pre_off_q <= pre_n;
        mrs_off_q <= mrs_n;
        end_q     <= end_n;
      end else if (busy) begin
        t_q <= t_q + cnt_t'(1);
        if (t_q == end_q) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    cmd_n      = C_NOP;
    cmd_a10    = 1'b0;
    cmd_bank   = busy ? bank_q : 2'd0;
    dqm        = 1'b0;
    wr_valid   = 1'b0;
    rd_capture = 1'b0;
    if (busy) begin
      case (op_q)
        OP_ACT: if (t_q == '0) cmd_n = C_ACT;
        OP_WR: begin
          if (t_q == '0) cmd_n = C_WR;
          else if (!pre_q && t_q == len_q) cmd_n = C_BST;
          else if (pre_q && t_q == pre_off_q) cmd_n = C_PRE;
          wr_valid = t_q < len_q;
          dqm      = pre_q && t_q >= len_q && t_q <= pre_off_q;
        end
        OP_RD: begin
          if (t_q == '0) cmd_n = C_RD;
          else if (!pre_q && t_q == len_q) cmd_n = C_BST;
          else if (pre_q && t_q == pre_off_q) cmd_n = C_PRE;
          rd_capture = t_q >= cl_q && t_q < cl_q + len_q;
          dqm        = pre_q && t_q + cnt_t'(2) >= len_q + cl_q && t_q + cnt_t'(3) <= pre_off_q + cl_q;
        end
        default: begin
          if (pre_q && t_q == pre_off_q) begin
            cmd_n   = C_PRE;
            cmd_a10 = 1'b1;
          end else if (t_q == mrs_off_q) cmd_n = C_MRS;
        end
      endcase
    end
  end
endmodule

// File: rtl/sdr_trunc_seq_chk.sv
module sdr_trunc_seq_chk #(
  parameter int T_RAS = 6,
  parameter int T_RP  = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic [3:0] cmd_n,
  input logic       cmd_a10,
  input logic [1:0] cmd_bank,
  input logic       dqm,
  input logic       wr_valid,
  input logic       rd_capture
);
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_BST = 4'b0110,
                         C_PRE = 4'b0010, C_MRS = 4'b0000;

  logic [15:0] since_pre;
  logic [15:0] age [4];
  logic [3:0]  open_c;
  logic        all_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= 16'(T_RP);
      open_c    <= '0;
      for (int b = 0; b < 4; b++) age[b] <= 16'(T_RAS);
    end else begin
      if (cmd_n == C_PRE) since_pre <= 16'd1;
      else if (since_pre < 16'(T_RP)) since_pre <= since_pre + 16'd1;
      for (int b = 0; b < 4; b++) begin
        if (cmd_n == C_ACT && cmd_bank == 2'(b)) begin
          age[b]    <= 16'd1;
          open_c[b] <= 1'b1;
        end else begin
          if (age[b] < 16'(T_RAS)) age[b] <= age[b] + 16'd1;
          if (cmd_n == C_PRE && (cmd_a10 || cmd_bank == 2'(b))) open_c[b] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    all_ok = 1'b1;
    for (int b = 0; b < 4; b++)
      if (open_c[b] && age[b] < 16'(T_RAS)) all_ok = 1'b0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_n == C_NOP && !dqm && !wr_valid && !rd_capture));
  a_r3_write_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid) |-> (cmd_n == C_BST || dqm));
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_capture));
  a_r7_ras_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_PRE && !cmd_a10) |-> age[cmd_bank] >= 16'(T_RAS));
  a_r7_ras_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_PRE && cmd_a10) |-> all_ok);
  a_r8_trp_before_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_MRS) |-> since_pre >= 16'(T_RP));
  a_r8_mrs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_MRS) |-> open_c == 4'b0000);
  a_r8_mrs_gap1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_n == C_MRS) |-> cmd_n == C_NOP);
  a_r8_mrs_gap2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_n == C_MRS, 2) |-> cmd_n == C_NOP);
endmodule

bind sdr_trunc_seq sdr_trunc_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_n(cmd_n), .cmd_a10(cmd_a10),
  .cmd_bank(cmd_bank), .dqm(dqm), .wr_valid(wr_valid), .rd_capture(rd_capture));

// File: tb/sim_sdr_trunc_seq.sv
`timescale 1ns/1ps
module sim_sdr_trunc_seq;
  localparam int T_RDL = 2, T_RAS = 6, T_RP = 3;
  localparam int NOP = 7, ACT = 3, RD = 5, WR = 4, BST = 6, PRE = 2, MRS = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_pre = 1'b0;
  logic [1:0] req_op = '0, req_bank = '0, cas_lat = 2'd2;
  logic [2:0] req_len = '0;
  logic req_ready, cmd_a10, dqm, wr_valid, rd_capture;
  logic [3:0] cmd_n;
  logic [1:0] cmd_bank;

  always #4 clk = ~clk;

  sdr_trunc_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_len(req_len), .req_pre(req_pre), .cas_lat(cas_lat),
    .cmd_n(cmd_n), .cmd_a10(cmd_a10), .cmd_bank(cmd_bank), .dqm(dqm),
    .wr_valid(wr_valid), .rd_capture(rd_capture));

  int now = 0;
  always @(posedge clk) now <= now + 1;

  int checks = 0, errors = 0;
  bit open_m [4];
  int act_m [4];

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", r, what, now, act, exp);
    end
  endtask

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run(int op, int bank, int len, int pre, int cs, string tag, int gap);
    int L, cl, c0, p, m, endt, anyo;
    repeat (gap) begin
      @(negedge clk);
      chk("R1", "ready while idle", req_ready, 1);
      chk("R1", "idle command", cmd_n, NOP);
    end
    chk("R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = 2'(op); req_bank = 2'(bank); req_len = 3'(len);
    req_pre = pre[0]; cas_lat = 2'(cs);
    @(negedge clk);
    req_valid = 1'b0;
    c0 = now;
    L = len + 1;
    cl = (cs == 3) ? 3 : 2;
    p = 0; m = 0; anyo = 0;
    case (op)
      0: endt = 0;
      2: begin
        p = mx(L - 1 + T_RDL, T_RAS - (c0 - act_m[bank]));
        endt = pre ? p + T_RP - 1 : L;
      end
      1: begin
        p = mx(L, T_RAS - (c0 - act_m[bank]));
        endt = pre ? mx(p + T_RP - 1, L + cl - 1) : L + cl - 1;
      end
      default: begin
        for (int b = 0; b < 4; b++)
          if (open_m[b]) begin
            anyo = 1;
            p = mx(p, T_RAS - (c0 - act_m[b]));
          end
        m = anyo ? p + T_RP : 0;
        endt = m + 1;
      end
    endcase
    for (int t = 0; t <= endt; t++) begin
      int ec, ea, ed, ew, er;
      ec = NOP; ea = 0; ed = 0; ew = 0; er = 0;
      case (op)
        0: if (t == 0) ec = ACT;
        2: begin
          if (t == 0) ec = WR;
          else if (pre == 0 && t == L) ec = BST;
          else if (pre != 0 && t == p) ec = PRE;
          ew = (t < L);
          ed = (pre != 0 && t >= L && t <= p);
        end
        1: begin
          if (t == 0) ec = RD;
          else if (pre == 0 && t == L) ec = BST;
          else if (pre != 0 && t == p) ec = PRE;
          er = (t >= cl && t <= cl + L - 1);
          ed = (pre != 0 && t >= L + cl - 2 && t <= p + cl - 3);
        end
        default: begin
          if (anyo != 0 && t == p) begin ec = PRE; ea = 1; end
          else if (t == m) ec = MRS;
        end
      endcase
      chk(tag, "command", cmd_n, ec);
      chk(tag, "a10", cmd_a10, ea);
      chk(tag, "dqm", dqm, ed);
      chk(tag, "wr_valid", wr_valid, ew);
      chk(tag, "rd_capture", rd_capture, er);
      chk("R1", "ready while busy", req_ready, 0);
      if (ec == ACT || ec == RD || ec == WR || (ec == PRE && ea == 0))
        chk(tag, "bank", cmd_bank, bank);
      @(negedge clk);
    end
    chk("R9", "ready after sequence", req_ready, 1);
    chk("R9", "bus quiet after sequence", cmd_n, NOP);
    if (op == 0) begin open_m[bank] = 1; act_m[bank] = c0; end
    else if (op == 3) for (int b = 0; b < 4; b++) open_m[b] = 0;
    else if (pre != 0) open_m[bank] = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got 0 expected 1 for completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin open_m[b] = 0; act_m[b] = -1000; end
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset command", cmd_n, NOP);
    chk("R1", "reset dqm", dqm, 0);
    chk("R1", "reset strobes", wr_valid | rd_capture, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 0, 0, 0, 2, "R2", 0);
    run(2, 0, 3, 0, 2, "R3", 8);
    run(1, 0, 1, 0, 2, "R5", 0);
    run(1, 0, 1, 0, 3, "R10", 0);
    run(1, 0, 0, 0, 3, "R10", 0);
    run(2, 0, 7, 0, 2, "R11", 0);
    run(1, 0, 2, 1, 3, "R6", 0);
    run(0, 1, 0, 0, 2, "R2", 0);
    run(1, 1, 1, 1, 2, "R7", 0);
    run(0, 2, 0, 0, 2, "R2", 0);
    run(2, 2, 0, 1, 2, "R7", 0);
    run(0, 3, 0, 0, 2, "R2", 0);
    run(2, 3, 1, 1, 2, "R4", 10);
    run(3, 0, 0, 0, 2, "R8", 0);
    run(0, 0, 0, 0, 2, "R2", 0);
    run(0, 3, 0, 0, 2, "R2", 0);
    run(3, 0, 0, 0, 2, "R8", 0);
    run(0, 1, 0, 0, 2, "R2", 0);
    run(1, 1, 3, 1, 3, "R6", 0);
    run(0, 2, 0, 0, 2, "R2", 0);
    run(1, 2, 0, 1, 3, "R6", 10);
    run(2, 1, 4, 0, 2, "R3", 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule